// File: doc/BRIEF.md
# UART Transmit Ring-Buffer DMA Channel

This block is one transmit DMA channel serving a byte-wide UART. Software keeps a circular buffer in memory. It places bytes in that buffer and then moves a write pointer forward. The channel keeps its own read pointer. Whenever the read pointer trails the write pointer, the channel fetches bytes one at a time through a simple byte-read memory port and offers them to the UART over a valid/ready byte stream.

Each ring pointer is a byte offset with a wrap-parity bit placed directly above it. Because of that bit, the channel can tell a full ring from an empty one without spending an extra slot. The channel works out two figures from the pointers: the fill, which is the number of bytes still to be fetched, and the space, which is the number of bytes software may still write. An interrupt flag is raised while the space is at least a programmed threshold, which software normally sets to 7/8 of the ring length.

Software controls the channel through a small register set with 32-bit word offsets:

| Offset | Register |
|---|---|
| 0x00 | interrupt flag |
| 0x04 | interrupt enable |
| 0x08 | enable |
| 0x0C | warm reset |
| 0x10 | stop request |
| 0x14 | flush |
| 0x1C | base address, low 32 bits |
| 0x24 | ring length |
| 0x28 | threshold |
| 0x2C | write pointer |
| 0x30 | read pointer |
| 0x3C | fill |
| 0x40 | space |
| 0x50 | debug |
| 0x54 | base address, upper bits |

Two handshakes let software synchronise with the hardware. The flush handshake lets it wait until all pending bytes have drained. The stop handshake lets it park the channel.

Top module: `uart_txdma_chan`

## Requirements
- R1: After reset the enable register reads 0, both pointers read 0, the fill reads 0, `tx_valid`, `mem_rd` and `irq` are 0.
- R2: The read pointer reads back as a wrap bit at bit 16 above a 16-bit offset. Each fetched byte adds 1 to the offset. When the sum reaches the ring length, the length is subtracted and the wrap bit inverts.
- R3: The fill register (0x3C) reads write offset minus read offset, plus the length when the two wrap bits differ. The space register (0x40) reads length minus fill.
- R4: The delivered bytes are those stored at base + read offset, in ring order. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold.
- R5: While enable is 0, no memory read is issued and the read pointer holds.
- R6: At most one memory read is outstanding. A new read is issued only when the output holding stage is empty, so with the UART stalled the read pointer runs exactly one byte ahead of delivery.
- R7: While enabled, the interrupt flag (0x00 bit 0) sets whenever space ≥ threshold. Any write to 0x00 clears it. `irq` equals the flag gated by interrupt-enable bit 0.
- R8: Writing 1 to bit 0 of the flush register makes it read 1. It returns to 0 once fill is 0, no read is outstanding and the output stage is empty.
- R9: While the stop request (0x10 bit 0) is 1, the channel issues no new reads, drops enable to 0 once no read is outstanding, and ignores writes to enable.
- R10: Writing 1 to bit 0 of the reset register clears enable, both pointers, stop, flush, the interrupt flag and the output stage, and keeps the configuration.
- R11: The memory address is the 33-bit sum {upper base (0x54 bit 0), low base (0x1C)} + read offset, with the carry propagating into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| mem_rd | output | 1 | Memory byte read request |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| tx_valid | output | 1 | Byte available to the UART |
| tx_data | output | 8 | Byte to the UART |
| tx_ready | input | 1 | UART accepts the byte |
| irq | output | 1 | Transmit interrupt |

## Verification
A wrong pointer step or a missed wrap-bit toggle shows up at once in two places. The next delivered byte comes from the wrong address, and the read pointer reads back a wrong value once a flush completes. A miscounted fill or space shows in the size registers and in `irq` in the same cycle as the pointer change. A stuck or lost fetch state either stalls the flush handshake, which the bench's drain poll catches within a few hundred cycles, or shows as a byte that disappears or repeats on the UART stream at the next handshake.

// File: rtl/uart_txdma_pkg.sv
package uart_txdma_pkg;

  localparam logic [7:0] RG_IFLAG  = 8'h00;
  localparam logic [7:0] RG_IEN    = 8'h04;
  localparam logic [7:0] RG_EN     = 8'h08;
  localparam logic [7:0] RG_RST    = 8'h0C;
  localparam logic [7:0] RG_STOP   = 8'h10;
  localparam logic [7:0] RG_FLUSH  = 8'h14;
  localparam logic [7:0] RG_BASE   = 8'h1C;
  localparam logic [7:0] RG_LEN    = 8'h24;
  localparam logic [7:0] RG_THR    = 8'h28;
  localparam logic [7:0] RG_WPTR   = 8'h2C;
  localparam logic [7:0] RG_RPTR   = 8'h30;
  localparam logic [7:0] RG_FILL   = 8'h3C;
  localparam logic [7:0] RG_SPACE  = 8'h40;
  localparam logic [7:0] RG_DBG    = 8'h50;
  localparam logic [7:0] RG_BASEHI = 8'h54;

  typedef struct packed {
    logic stop_req;
    logic flush_busy;
    logic out_busy;
    logic fetch_busy;
  } dbg_t;

endpackage

// File: rtl/uart_txdma_ring.sv
module uart_txdma_ring #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W:0]   wr_ptr,
  input  logic [OFS_W:0]   rd_ptr,
  input  logic [OFS_W-1:0] ring_len,
  output logic [OFS_W:0]   fill,
  output logic [OFS_W:0]   space
);

  // Bytes between the read and write pointers, using the wrap parity.
  function automatic logic [OFS_W:0] ring_fill(
    input logic [OFS_W:0]   w,
    input logic [OFS_W:0]   r,
    input logic [OFS_W-1:0] l
  );
    logic [OFS_W:0] d;
    d = {1'b0, w[OFS_W-1:0]} - {1'b0, r[OFS_W-1:0]};
    if (w[OFS_W] != r[OFS_W]) d = d + {1'b0, l};
    return d;
  endfunction

  always_comb begin
    fill  = ring_fill(wr_ptr, rd_ptr, ring_len);
    space = {1'b0, ring_len} - fill;
  end

endmodule

// File: rtl/uart_txdma_regs.sv
module uart_txdma_regs
  import uart_txdma_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int MEM_AW = 33,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [OFS_W:0]    rd_ptr,
  input  logic [OFS_W:0]    fill,
  input  logic [OFS_W:0]    space,
  input  logic              fetch_busy,
  input  logic              out_busy,
  output logic              ch_en,
  output logic              stop_req,
  output logic              warm_rst,
  output logic [OFS_W:0]    wr_ptr,
  output logic [OFS_W-1:0]  ring_len,
  output logic [MEM_AW-1:0] base_addr,
  output logic              irq
);

  localparam int HI_W = MEM_AW - 32;

  logic              iflag_q, ien_q, flush_q;
  logic [OFS_W-1:0]  thr_q;
  logic [31:0]       base_lo_q;
  logic [HI_W-1:0]   base_hi_q;
  logic              drained;
  dbg_t              dbg;

  function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] r);
    return a == REG_AW'(r);
  endfunction

  assign warm_rst  = cfg_wr && hit(cfg_addr, RG_RST) && cfg_wdata[0];
  assign drained   = (fill == '0) && !fetch_busy && !out_busy;
  assign base_addr = {base_hi_q, base_lo_q};
  assign irq       = iflag_q & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en     <= 1'b0;
      stop_req  <= 1'b0;
      flush_q   <= 1'b0;
      iflag_q   <= 1'b0;
      ien_q     <= 1'b0;
      wr_ptr    <= '0;
      ring_len  <= '0;
      thr_q     <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (warm_rst) begin
      ch_en    <= 1'b0;
      stop_req <= 1'b0;
      flush_q  <= 1'b0;
      iflag_q  <= 1'b0;
      wr_ptr   <= '0;
    end else begin
      // enable: stop request wins over software writes
      if (stop_req && !fetch_busy) ch_en <= 1'b0;
      else if (cfg_wr && hit(cfg_addr, RG_EN) && !stop_req) ch_en <= cfg_wdata[0];

      if (cfg_wr && hit(cfg_addr, RG_STOP)) stop_req <= cfg_wdata[0];

      if (cfg_wr && hit(cfg_addr, RG_FLUSH) && cfg_wdata[0]) flush_q <= 1'b1;
      else if (flush_q && drained) flush_q <= 1'b0;

      if (cfg_wr && hit(cfg_addr, RG_IFLAG)) iflag_q <= 1'b0;
      else if (ch_en && (space >= {1'b0, thr_q})) iflag_q <= 1'b1;

      if (cfg_wr && hit(cfg_addr, RG_IEN))    ien_q     <= cfg_wdata[0];
      if (cfg_wr && hit(cfg_addr, RG_WPTR))   wr_ptr    <= cfg_wdata[OFS_W:0];
      if (cfg_wr && hit(cfg_addr, RG_LEN))    ring_len  <= cfg_wdata[OFS_W-1:0];
      if (cfg_wr && hit(cfg_addr, RG_THR))    thr_q     <= cfg_wdata[OFS_W-1:0];
      if (cfg_wr && hit(cfg_addr, RG_BASE))   base_lo_q <= cfg_wdata;
      if (cfg_wr && hit(cfg_addr, RG_BASEHI)) base_hi_q <= cfg_wdata[HI_W-1:0];
    end
  end

  always_comb begin
    dbg = '{stop_req: stop_req, flush_busy: flush_q,
            out_busy: out_busy, fetch_busy: fetch_busy};
    cfg_rdata = '0;
    if      (hit(cfg_addr, RG_IFLAG))  cfg_rdata = 32'(iflag_q);
    else if (hit(cfg_addr, RG_IEN))    cfg_rdata = 32'(ien_q);
    else if (hit(cfg_addr, RG_EN))     cfg_rdata = 32'(ch_en);
    else if (hit(cfg_addr, RG_STOP))   cfg_rdata = 32'(stop_req);
    else if (hit(cfg_addr, RG_FLUSH))  cfg_rdata = 32'(flush_q);
    else if (hit(cfg_addr, RG_BASE))   cfg_rdata = base_lo_q;
    else if (hit(cfg_addr, RG_LEN))    cfg_rdata = 32'(ring_len);
    else if (hit(cfg_addr, RG_THR))    cfg_rdata = 32'(thr_q);
    else if (hit(cfg_addr, RG_WPTR))   cfg_rdata = 32'(wr_ptr);
    else if (hit(cfg_addr, RG_RPTR))   cfg_rdata = 32'(rd_ptr);
    else if (hit(cfg_addr, RG_FILL))   cfg_rdata = 32'(fill);
    else if (hit(cfg_addr, RG_SPACE))  cfg_rdata = 32'(space);
    else if (hit(cfg_addr, RG_DBG))    cfg_rdata = 32'(dbg);
    else if (hit(cfg_addr, RG_BASEHI)) cfg_rdata = 32'(base_hi_q);
  end

endmodule

// File: rtl/uart_txdma_fetch.sv
module uart_txdma_fetch #(
  parameter int OFS_W  = 16,
  parameter int MEM_AW = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              ch_en,
  input  logic              stop_req,
  input  logic [OFS_W:0]    fill,
  input  logic [OFS_W-1:0]  ring_len,
  input  logic [MEM_AW-1:0] base_addr,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic [OFS_W:0]    rd_ptr,
  output logic              inflight
);

  logic       out_v_q;
  logic [7:0] out_d_q;
  logic       fetch_go;

  // One-byte pointer step with wrap-parity toggle at the ring length.
  function automatic logic [OFS_W:0] ptr_step(
    input logic [OFS_W:0]   p,
    input logic [OFS_W-1:0] l
  );
    logic [OFS_W:0] s;
    s = {1'b0, p[OFS_W-1:0]} + 1'b1;
    if (s >= {1'b0, l}) begin
      s = s - {1'b0, l};
      return {~p[OFS_W], s[OFS_W-1:0]};
    end
    return {p[OFS_W], s[OFS_W-1:0]};
  endfunction

  assign fetch_go = ch_en && !stop_req && (fill != '0) && !inflight && !out_v_q;
  assign mem_rd   = fetch_go;
  assign mem_addr = base_addr + {{(MEM_AW-OFS_W){1'b0}}, rd_ptr[OFS_W-1:0]};
  assign tx_valid = out_v_q;
  assign tx_data  = out_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      inflight <= 1'b0;
      out_v_q  <= 1'b0;
      out_d_q  <= '0;
    end else if (warm_rst) begin
      rd_ptr   <= '0;
      inflight <= 1'b0;
      out_v_q  <= 1'b0;
    end else begin
      if (fetch_go) rd_ptr <= ptr_step(rd_ptr, ring_len);
      inflight <= fetch_go;
      if (inflight) begin
        out_v_q <= 1'b1;
        out_d_q <= mem_rdata;
      end else if (out_v_q && tx_ready) begin
        out_v_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_txdma_chan.sv
module uart_txdma_chan #(
  parameter int OFS_W  = 16,
  parameter int MEM_AW = 33,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  logic              ch_en, stop_req, warm_rst, fetch_inflight;
  logic [OFS_W:0]    wr_ptr, rd_ptr, valid_sz, left_sz;
  logic [OFS_W-1:0]  ring_len;
  logic [MEM_AW-1:0] base_addr;

  uart_txdma_regs #(.OFS_W(OFS_W), .MEM_AW(MEM_AW), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_ptr(rd_ptr), .fill(valid_sz), .space(left_sz),
    .fetch_busy(fetch_inflight), .out_busy(tx_valid),
    .ch_en(ch_en), .stop_req(stop_req), .warm_rst(warm_rst),
    .wr_ptr(wr_ptr), .ring_len(ring_len), .base_addr(base_addr), .irq(irq)
  );

  uart_txdma_ring #(.OFS_W(OFS_W)) ring_i (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ring_len(ring_len),
    .fill(valid_sz), .space(left_sz)
  );

  uart_txdma_fetch #(.OFS_W(OFS_W), .MEM_AW(MEM_AW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .ch_en(ch_en), .stop_req(stop_req), .fill(valid_sz), .ring_len(ring_len),
    .base_addr(base_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rd_ptr(rd_ptr), .inflight(fetch_inflight)
  );

endmodule

// File: rtl/uart_txdma_chk.sv
module uart_txdma_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             ch_en,
  input logic             stop_req,
  input logic             warm_rst,
  input logic             inflight,
  input logic [OFS_W:0]   vsize,
  input logic [OFS_W-1:0] len
);

  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !mem_rd);  // R6
  AST_NO_FETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !mem_rd);  // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !warm_rst) |=> (tx_valid && $stable(tx_data)));  // R4
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    vsize <= {1'b0, len});  // R3
  AST_FETCH_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (vsize != '0));  // R3
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !inflight) |=> !ch_en);  // R9

endmodule

bind uart_txdma_chan uart_txdma_chk #(.OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .ch_en(ch_en), .stop_req(stop_req), .warm_rst(warm_rst),
  .inflight(fetch_inflight), .vsize(valid_sz), .len(ring_len)
);

// File: tb/uart_txdma_chan_tb_top.sv
`timescale 1ns/1ps
module uart_txdma_chan_tb_top;

  localparam logic [7:0] A_IFLAG = 8'h00, A_IEN = 8'h04, A_EN = 8'h08, A_RST = 8'h0C,
                         A_STOP = 8'h10, A_FLUSH = 8'h14, A_BASE = 8'h1C, A_LEN = 8'h24,
                         A_THR = 8'h28, A_WPTR = 8'h2C, A_RPTR = 8'h30, A_FILL = 8'h3C,
                         A_SPACE = 8'h40, A_BASEHI = 8'h54;

  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        mem_rd;
  logic [32:0] mem_addr;
  logic [7:0]  mem_rdata = 0;
  logic        tx_valid, tx_ready = 0, irq;
  logic [7:0]  tx_data;

  int n_chk = 0, n_fail = 0;
  int len_cur = 16;
  logic [32:0] base_cur = 0;
  int exp_wp = 0, exp_rp = 0;
  bit sink_on = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_txdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  function automatic logic [7:0] mem_byte(input logic [32:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ a[31:24] ^ (a[32] ? 8'hA5 : 8'h00);
  endfunction

  // linear position in [0, 2*len) -> {wrap, offset}
  function automatic logic [31:0] lin2ptr(input int p, input int l);
    return {15'd0, (p >= l), 16'(p % l)};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // UART sink: random ready, byte checked against the ring model (R4, R11)
  always @(negedge clk) begin
    if (sink_on) tx_ready = ($urandom % 4) != 0;
    else tx_ready = 0;
    if (rst_n && tx_valid && tx_ready) begin
      chk("R4/R11 byte order", {24'd0, tx_data},
          {24'd0, mem_byte(base_cur + 33'(exp_rp % len_cur))});
      exp_rp = (exp_rp + 1) % (2 * len_cur);
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic advance_wp(input int n);
    exp_wp = (exp_wp + n) % (2 * len_cur);
    reg_wr(A_WPTR, lin2ptr(exp_wp, len_cur));
  endtask

  task automatic flush_drain();
    logic [31:0] d;
    sink_on = 1;
    reg_wr(A_FLUSH, 1);
    for (int i = 0; i < 600; i++) begin
      reg_rd(A_FLUSH, d);
      if (d[0] == 1'b0) break;
    end
    chk("R8 flush returns to 0", d, 0);
    chk("R4 all bytes delivered", 32'(exp_rp), 32'(exp_wp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 mem_rd", {31'd0, mem_rd}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd_chk("R1 enable", A_EN, 0);
    rd_chk("R1 rptr", A_RPTR, 0);
    rd_chk("R1 wptr", A_WPTR, 0);
    rd_chk("R1 fill", A_FILL, 0);

    // configure
    base_cur = 33'h0_0000_1000; len_cur = 16;
    reg_wr(A_LEN, 16); reg_wr(A_THR, 14); reg_wr(A_BASE, 32'h1000);
    reg_wr(A_BASEHI, 0); reg_wr(A_IEN, 1); reg_wr(A_EN, 1);
    rd_chk("R7 flag set on free space", A_IFLAG, 1);
    chk("R7 irq high", {31'd0, irq}, 1);
    rd_chk("R3 space empty ring", A_SPACE, 16);

    // stalled UART: one byte fetched ahead
    sink_on = 0;
    advance_wp(10);
    repeat (10) @(negedge clk);
    rd_chk("R6 one byte ahead", A_RPTR, 1);
    rd_chk("R3 fill", A_FILL, 9);
    rd_chk("R3 space", A_SPACE, 7);
    chk("R4 output held valid", {31'd0, tx_valid}, 1);
    chk("R4 first byte", {24'd0, tx_data}, {24'd0, mem_byte(33'h1000)});
    reg_wr(A_IFLAG, 0);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    sink_on = 1;
    reg_wr(A_FLUSH, 1);
    rd_chk("R8 flush busy", A_FLUSH, 1);
    flush_drain();
    rd_chk("R2 rptr", A_RPTR, lin2ptr(10, 16));

    // wrap across the ring end
    sink_on = 0;
    advance_wp(10);
    repeat (10) @(negedge clk);
    rd_chk("R3 fill with differing wrap", A_FILL, 9);
    flush_drain();
    rd_chk("R2 wrapped rptr", A_RPTR, 32'h0001_0004);

    // disabled channel
    reg_wr(A_EN, 0);
    advance_wp(3);
    repeat (20) @(negedge clk);
    rd_chk("R5 rptr holds", A_RPTR, lin2ptr(20, 16));
    chk("R5 no output", {31'd0, tx_valid}, 0);
    rd_chk("R3 fill while off", A_FILL, 3);
    reg_wr(A_EN, 1);
    flush_drain();
    rd_chk("R2 rptr after resume", A_RPTR, lin2ptr(23, 16));

    // stop handshake
    sink_on = 0;
    advance_wp(8);
    repeat (10) @(negedge clk);
    reg_wr(A_STOP, 1);
    repeat (5) @(negedge clk);
    rd_chk("R9 enable dropped", A_EN, 0);
    reg_wr(A_EN, 1);
    rd_chk("R9 enable write ignored", A_EN, 0);
    reg_wr(A_STOP, 0);
    reg_wr(A_EN, 1);
    rd_chk("R9 enable after stop", A_EN, 1);
    flush_drain();
    rd_chk("R2 rptr full wrap", A_RPTR, lin2ptr(31, 16));

    // warm reset
    sink_on = 0;
    advance_wp(5);
    repeat (10) @(negedge clk);
    reg_wr(A_RST, 1);
    rd_chk("R10 enable", A_EN, 0);
    rd_chk("R10 rptr", A_RPTR, 0);
    rd_chk("R10 wptr", A_WPTR, 0);
    chk("R10 output dropped", {31'd0, tx_valid}, 0);
    rd_chk("R10 length kept", A_LEN, 16);
    exp_wp = 0; exp_rp = 0;
    reg_wr(A_EN, 1);

    // upper address bit and carry
    base_cur = 33'h0_FFFF_FFFC;
    reg_wr(A_BASE, 32'hFFFF_FFFC);
    advance_wp(8);
    flush_drain();
    base_cur = 33'h1_0000_0040;
    reg_wr(A_BASEHI, 1); reg_wr(A_BASE, 32'h40);
    advance_wp(6);
    flush_drain();
    rd_chk("R11 rptr", A_RPTR, lin2ptr(14, 16));

    // random bursts on a 37-byte ring
    reg_wr(A_RST, 1);
    exp_wp = 0; exp_rp = 0; len_cur = 37;
    base_cur = 33'h0_0000_2000;
    reg_wr(A_LEN, 37); reg_wr(A_THR, 32); reg_wr(A_BASEHI, 0);
    reg_wr(A_BASE, 32'h2000); reg_wr(A_EN, 1);
    for (int i = 0; i < 12; i++) begin
      advance_wp(1 + int'($urandom % 37));
      flush_drain();
      rd_chk("R2 random rptr", A_RPTR, lin2ptr(exp_wp, 37));
      rd_chk("R3 random fill", A_FILL, 0);
      rd_chk("R3 random space", A_SPACE, 37);
      chk("R7 irq after drain", {31'd0, irq}, 1);
    end
    reg_rd(A_RPTR, d);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule